// File: doc/BRIEF.md
# Rotating Predicate Loop Controller

This block sequences a software-pipelined loop. It keeps a loop counter, a drain counter and a ring of stage-enable predicates, 48 wide by default. Each predicate guards one pipeline stage. Output bit 0 carries the architectural predicate number 16 and guards the first stage (A). Bit 1 carries predicate 17 and guards stage B, and so on up to bit 47, which carries predicate 63.

Software arms the block with one initialize command that supplies the trip count and the stage count. At the end of every pipeline stage it pulses a stage-end strobe. The block then takes one loop-branch step:
- It picks a new stage-enable bit, which is 1 while iterations remain and 0 while the pipeline drains.
- It shifts the ring up by one place and writes the new bit into the lowest place.
- It reports whether the loop branch is taken.

Once the last stage has drained, the branch falls through and a sticky done flag rises.

Top module: `rpl_loop_ctrl`

## Requirements
- R1: After synchronous reset, `stage_pred` is all zeros and `br_taken` and `loop_done` are 0. A `stage_end` that arrives before the first initialize changes no output.
- R2: One cycle after `init_valid`, `stage_pred` equals 1 in bit 0 and 0 everywhere else, and `loop_done` and `br_taken` are 0. The loop counter is loaded with the trip count minus one, and a trip count of 0 acts as 1. The drain counter is loaded with the stage count. When `init_valid` and `stage_end` arrive in the same cycle, the initialize wins and the strobe is dropped.
- R3: One cycle after an accepted `stage_end`, each `stage_pred` bit i+1 holds the previous bit i, and bit 0 holds the new stage-enable bit. The previous bit 47 is dropped: it wraps around to bit 0, where the new bit overwrites it.
- R4: Kernel step. When the loop counter is nonzero, the counter decrements, the new bit is 1, and `br_taken` is 1 for the one following cycle.
- R5: Drain step. When the loop counter is zero and the drain counter is greater than 1, the drain counter decrements, the new bit is 0, and `br_taken` is 1 for the one following cycle.
- R6: Exit step. When the loop counter is zero and the drain counter is 1 or less, the drain counter becomes 0, the new bit is 0, `br_taken` stays 0, and `loop_done` is 1 in the following cycle.
- R7: Take a trip count N ≥ 1 and a stage count S ≥ 1. The branch is then taken exactly N+S-2 times before the exit. Every stage k < S has its `stage_pred` bit high in exactly N stage slots. For example, 5 stages and 2 iterations give 5 taken branches, and stage A is enabled in 2 slots.
- R8: Once `loop_done` is set, `stage_end` strobes change neither `stage_pred` nor `br_taken` until the next initialize.
- R9: `loop_done` stays at 1 until the next `init_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_valid | input | 1 | Initialize command |
| init_trip | input | LC_W | Trip count for the coming loop |
| init_stages | input | EC_W | Number of pipeline stages |
| stage_end | input | 1 | End-of-stage strobe that triggers one loop-branch step |
| stage_pred | output | NUM_PRED | Stage enables; bit i is rotating predicate 16+i |
| br_taken | output | 1 | One-cycle pulse: the loop branch of the last step was taken |
| loop_done | output | 1 | Sticky flag: the loop has exited |

## Verification
The bench builds the block with the default 48-entry ring, an 8-bit loop counter and a 6-bit drain counter. The 6-bit drain counter allows stage counts above 48. A 50-stage run therefore pushes enabled bits out through the top place of the ring and shows that they are dropped, not wrapped back into stage A. The 8-bit trip field reaches the trip-count-of-zero corner. The short cases (1 stage, 1 iteration, 0 stages) put the exit directly after the kernel steps or at the first strobe.

// File: rtl/rpl_pkg.sv
package rpl_pkg;

    // Kind of loop-branch step chosen at a stage end
    typedef enum logic [1:0] {
        STEP_KERNEL = 2'd0,
        STEP_DRAIN  = 2'd1,
        STEP_EXIT   = 2'd2
    } step_kind_e;

    typedef struct packed {
        step_kind_e kind;
        logic       taken;
        logic       new_bit;
    } step_t;

    // Choose the step from the counter state
    function automatic step_t classify(input logic lc_zero, input logic ec_more);
        step_t s;
        if (!lc_zero) begin
            s.kind    = STEP_KERNEL;
            s.taken   = 1'b1;
            s.new_bit = 1'b1;
        end else if (ec_more) begin
            s.kind    = STEP_DRAIN;
            s.taken   = 1'b1;
            s.new_bit = 1'b0;
        end else begin
            s.kind    = STEP_EXIT;
            s.taken   = 1'b0;
            s.new_bit = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/rpl_counters.sv
module rpl_counters
    import rpl_pkg::*;
#(
    parameter int LC_W = 16,
    parameter int EC_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [LC_W-1:0] trip,
    input  logic [EC_W-1:0] stages,
    input  logic            advance,
    output step_t           step
);
    localparam logic [LC_W-1:0] LC_ONE = LC_W'(1);
    localparam logic [EC_W-1:0] EC_ONE = EC_W'(1);

    logic [LC_W-1:0] lc_q;
    logic [EC_W-1:0] ec_q;
    logic [LC_W-1:0] lc_load;

    // A trip count of zero behaves as a single iteration
    assign lc_load = (trip == '0) ? '0 : trip - LC_ONE;

    always_comb begin
        step = classify(lc_q == '0, ec_q > EC_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lc_q <= '0;
            ec_q <= '0;
        end else if (load) begin
            lc_q <= lc_load;
            ec_q <= stages;
        end else if (advance) begin
            unique case (step.kind)
                STEP_KERNEL: lc_q <= lc_q - LC_ONE;
                STEP_DRAIN:  ec_q <= ec_q - EC_ONE;
                default:     ec_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rpl_pred_ring.sv
module rpl_pred_ring #(
    parameter int NUM_PRED = 48
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                shift,
    input  logic                new_bit,
    output logic [NUM_PRED-1:0] pred
);
    // Place 0 takes the new enable; each higher place takes its lower neighbour
    for (genvar i = 0; i < NUM_PRED; i++) begin : g_slot
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)        pred[i] <= 1'b0;
                else if (load)  pred[i] <= 1'b1;
                else if (shift) pred[i] <= new_bit;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)        pred[i] <= 1'b0;
                else if (load)  pred[i] <= 1'b0;
                else if (shift) pred[i] <= pred[i-1];
            end
        end
    end
endmodule

// File: rtl/rpl_loop_ctrl.sv
module rpl_loop_ctrl
    import rpl_pkg::*;
#(
    parameter int NUM_PRED = 48,
    parameter int LC_W     = 16,
    parameter int EC_W     = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                init_valid,
    input  logic [LC_W-1:0]     init_trip,
    input  logic [EC_W-1:0]     init_stages,
    input  logic                stage_end,
    output logic [NUM_PRED-1:0] stage_pred,
    output logic                br_taken,
    output logic                loop_done
);
    logic  armed;
    logic  fire;
    step_t step;

    // A strobe counts only while a loop is armed and no initialize is pending
    assign fire = stage_end && armed && !init_valid;

    rpl_counters #(.LC_W(LC_W), .EC_W(EC_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (init_valid),
        .trip    (init_trip),
        .stages  (init_stages),
        .advance (fire),
        .step    (step)
    );

    rpl_pred_ring #(.NUM_PRED(NUM_PRED)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .load    (init_valid),
        .shift   (fire),
        .new_bit (step.new_bit),
        .pred    (stage_pred)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            loop_done <= 1'b0;
            br_taken  <= 1'b0;
        end else if (init_valid) begin
            armed     <= 1'b1;
            loop_done <= 1'b0;
            br_taken  <= 1'b0;
        end else if (fire) begin
            br_taken <= step.taken;
            if (step.kind == STEP_EXIT) begin
                armed     <= 1'b0;
                loop_done <= 1'b1;
            end
        end else begin
            br_taken <= 1'b0;
        end
    end
endmodule

// File: rtl/rpl_loop_ctrl_checker.sv
module rpl_loop_ctrl_checker #(
    parameter int NUM_PRED = 48
) (
    input logic                clk,
    input logic                rst,
    input logic                init_valid,
    input logic                stage_end,
    input logic                armed,
    input logic [NUM_PRED-1:0] stage_pred,
    input logic                br_taken,
    input logic                loop_done
);
    localparam logic [NUM_PRED-1:0] HEAD_ONLY = {{(NUM_PRED-1){1'b0}}, 1'b1};

    a_r2_init_pattern: assert property (@(posedge clk) disable iff (rst)
        init_valid |=> (stage_pred == HEAD_ONLY) && !loop_done && !br_taken);

    a_r3_rotate: assert property (@(posedge clk) disable iff (rst)
        (stage_end && armed && !init_valid)
            |=> stage_pred[NUM_PRED-1:1] == $past(stage_pred[NUM_PRED-2:0]));

    a_r8_ignored_strobe: assert property (@(posedge clk) disable iff (rst)
        (!init_valid && !(stage_end && armed)) |=> $stable(stage_pred) && !br_taken);

    a_r6_exit_not_taken: assert property (@(posedge clk) disable iff (rst)
        loop_done |-> !br_taken);

    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        (loop_done && !init_valid) |=> loop_done);
endmodule

bind rpl_loop_ctrl rpl_loop_ctrl_checker #(.NUM_PRED(NUM_PRED)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .init_valid (init_valid),
    .stage_end  (stage_end),
    .armed      (armed),
    .stage_pred (stage_pred),
    .br_taken   (br_taken),
    .loop_done  (loop_done)
);

// File: tb/rpl_loop_ctrl_test.sv
module rpl_loop_ctrl_test;
    localparam int NUM  = 48;
    localparam int LCW  = 8;
    localparam int ECW  = 6;
    localparam int NCASE = 8;
    // {trip count, stage count}
    localparam int CASES [NCASE][2] = '{
        '{2, 5}, '{1, 1}, '{0, 3}, '{4, 1},
        '{3, 4}, '{2, 50}, '{10, 2}, '{1, 0}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           init_valid = 1'b0;
    logic [LCW-1:0] init_trip = '0;
    logic [ECW-1:0] init_stages = '0;
    logic           stage_end = 1'b0;
    logic [NUM-1:0] stage_pred;
    logic           br_taken;
    logic           loop_done;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    // Reference state derived from the requirements
    logic [NUM-1:0] m_pred = '0;
    int             m_lc = 0;
    int             m_ec = 0;
    logic           m_armed = 1'b0;
    logic           m_done = 1'b0;
    logic           m_taken = 1'b0;

    always #4 clk = ~clk;

    rpl_loop_ctrl #(.NUM_PRED(NUM), .LC_W(LCW), .EC_W(ECW)) uut (
        .clk(clk), .rst(rst), .init_valid(init_valid), .init_trip(init_trip),
        .init_stages(init_stages), .stage_end(stage_end), .stage_pred(stage_pred),
        .br_taken(br_taken), .loop_done(loop_done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(stage_pred == m_pred, {req, " stage_pred"}, 64'(stage_pred), 64'(m_pred));
        chk(br_taken == m_taken, {req, " br_taken"}, 64'(br_taken), 64'(m_taken));
        chk(loop_done == m_done, {req, " loop_done"}, 64'(loop_done), 64'(m_done));
    endtask

    task automatic model_step();
        logic nb;
        m_taken = 1'b0;
        if (m_armed) begin
            if (m_lc != 0) begin
                m_lc--; nb = 1'b1; m_taken = 1'b1;           // R4
            end else if (m_ec > 1) begin
                m_ec--; nb = 1'b0; m_taken = 1'b1;           // R5
            end else begin
                m_ec = 0; nb = 1'b0; m_done = 1'b1; m_armed = 1'b0; // R6
            end
            m_pred = {m_pred[NUM-2:0], nb};                  // R3
        end
    endtask

    task automatic do_init(input int trip, input int stages, input bit with_strobe);
        @(negedge clk);
        init_valid = 1'b1; init_trip = LCW'(trip); init_stages = ECW'(stages);
        stage_end = with_strobe;
        @(negedge clk);
        init_valid = 1'b0; stage_end = 1'b0;
        m_pred = NUM'(1); m_lc = (trip == 0) ? 0 : trip - 1; m_ec = stages;
        m_armed = 1'b1; m_done = 1'b0; m_taken = 1'b0;
        compare("R2");
    endtask

    task automatic do_step(input string req);
        @(negedge clk);
        stage_end = 1'b1;
        @(negedge clk);
        stage_end = 1'b0;
        model_step();
        compare(req);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1 reset");
        // R1: strobe before any initialize is ignored
        do_step("R1 pre-init strobe");

        // Table walk: R3 R4 R5 R6 R7 per case
        for (int c = 0; c < NCASE; c++) begin
            int trip_n, stg, kbit, slots_a, slots_k, takes, guard, exp_takes;
            trip_n = (CASES[c][0] == 0) ? 1 : CASES[c][0];
            stg    = CASES[c][1];
            kbit   = (stg > NUM) ? NUM - 1 : stg - 1;
            slots_a = 0; slots_k = 0; takes = 0; guard = 0;
            do_init(CASES[c][0], stg, 1'b0);
            while (!loop_done && guard < 300) begin
                if (stage_pred[0]) slots_a++;
                if (kbit >= 0 && stage_pred[kbit]) slots_k++;
                do_step("R3 R4 R5 R6 step");
                if (br_taken) takes++;
                guard++;
            end
            exp_takes = trip_n - 1 + ((stg > 1) ? stg - 1 : 0);
            chk(takes == exp_takes, "R7 taken count", 64'(takes), 64'(exp_takes));
            chk(slots_a == trip_n, "R7 stage A slots", 64'(slots_a), 64'(trip_n));
            if (kbit >= 0)
                chk(slots_k == trip_n, "R7 last stage slots", 64'(slots_k), 64'(trip_n));
        end

        // R8 R9: strobes after exit are ignored, done holds
        for (int i = 0; i < 3; i++) do_step("R8 R9 post-exit strobe");

        // R2: initialize beats a simultaneous strobe, also mid-loop
        do_init(3, 3, 1'b0);
        do_step("R4 mid-loop");
        do_init(1, 2, 1'b1);
        do_step("R5 after re-init");
        do_step("R6 after re-init");
        chk(loop_done == 1'b1, "R6 done raised", 64'(loop_done), 64'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule